// File: doc/BRIEF.md
# Pin Input Conditioning and Event Interrupt Unit

This block forms the input side of a general-purpose pin port. Each pin's raw level may change at any time, with no relation to the clock. The block first resynchronizes every pin through a chain of flops. A per-pin selectable stability filter can then reject short glitches before the value reaches the readable pin-value register and the event detectors. Every pin is handled on its own: its own synchronizer bits, its own filter counter and its own event logic.

Four kinds of event are watched on each conditioned pin value: a rising edge, a falling edge, a high level and a low level. Each kind has its own per-pin enable register. A detected event sets a sticky per-pin status bit. Software clears a status bit by writing a one to it. Software can also raise status bits directly through a write-only injection register. A mask register decides which status bits drive the per-pin interrupt lines. Registers are reached through a simple single-cycle write port and a combinational read port, both addressed by a 4-bit select code.

Top module: `pev_top`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and every interrupt line is low.
- R2: A pin with its filter disabled shows a new input level in the pin-value register (select code 0) on the second rising clock edge after the level was present at an edge: a two-flop resynchronizer.
- R3: A pin with its filter enabled takes on a new synchronized level only after that level has been sampled on STABLE_CYCLES consecutive edges (default 16). A pulse shorter than that leaves the pin value unchanged.
- R4: The filter-enable register (code 8) selects filtering per pin. A bit at 0 passes the synchronized value straight through, and other pins are unaffected.
- R5: With the rising-edge enable bit set (code 4), a 0-to-1 change of the conditioned pin value sets that pin's status bit on the next edge.
- R6: With the falling-edge enable bit set (code 5), a 1-to-0 change sets that pin's status bit on the next edge.
- R7: With the high-level enable bit set (code 6), the status bit is set on every edge where the conditioned value is 1.
- R8: With the low-level enable bit set (code 7), the status bit is set on every edge where the conditioned value is 0.
- R9: Status bits (code 1) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: When a clear and a new event hit the same status bit on the same edge, the bit ends up set.
- R11: Writing the injection register (code 3) sets each status bit whose data bit is 1. The injection register always reads as zero.
- R12: Each interrupt line is the AND of its status bit and its mask bit (code 2), and is never unknown.
- R13: Read select codes 9 to 15 return zero. Register codes 2, 4, 5, 6, 7 and 8 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Raw pin levels, may be asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | NPINS | Read data of the selected register |
| irq_o | output | NPINS | Per-pin interrupt lines |

## Verification
The bench builds the block with NPINS = 8 and STABLE_CYCLES = 5. With five as the threshold, pulses of three, four, five and six cycles fall on both sides of it within a few dozen cycles. With eight pins, mixed filter masks and alternating event-enable patterns cover filtered and unfiltered pins side by side. A behavioural model predicts the read data and interrupt lines on every clock, including the cycles where a clear meets a held level event.

// File: rtl/pev_pkg.sv
package pev_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_PINS  = 4'd0,
        SEL_STATE = 4'd1,
        SEL_IEN   = 4'd2,
        SEL_FORCE = 4'd3,
        SEL_RISE  = 4'd4,
        SEL_FALL  = 4'd5,
        SEL_HIGH  = 4'd6,
        SEL_LOW   = 4'd7,
        SEL_FILT  = 4'd8
    } reg_sel_e;

    function automatic logic hits(input logic en, input logic [SEL_W-1:0] sel,
                                  input reg_sel_e tgt);
        return en && (sel == tgt);
    endfunction

endpackage

// File: rtl/pev_sync.sv
module pev_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    for (genvar k = 0; k < STAGES; k++) begin : g_stg
        logic [W-1:0] q;
        logic [W-1:0] d;
        if (k == 0) begin : g_first
            assign d = raw_i;
        end else begin : g_next
            assign d = g_stg[k-1].q;
        end
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end

    assign sync_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/pev_filter.sv
module pev_filter #(
    parameter int W      = 32,
    parameter int STABLE = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] val_o
);
    localparam int CW = $clog2(STABLE + 1);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic          last_q;
        logic          held_q;
        logic [CW-1:0] run_q;
        logic [CW-1:0] run_d;

        always_comb begin
            if (sync_i[i] != last_q)          run_d = CW'(1);
            else if (run_q >= CW'(STABLE))    run_d = CW'(STABLE);
            else                              run_d = run_q + CW'(1);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                last_q <= 1'b0;
                held_q <= 1'b0;
                run_q  <= '0;
            end else begin
                last_q <= sync_i[i];
                run_q  <= run_d;
                if (run_d >= CW'(STABLE)) held_q <= sync_i[i];
            end
        end

        assign val_o[i] = en_i[i] ? held_q : sync_i[i];
    end
endmodule

// File: rtl/pev_detect.sv
module pev_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic [W-1:0] high_en_i,
    input  logic [W-1:0] low_en_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] frc_i,
    output logic [W-1:0] val_q_o,
    output logic [W-1:0] state_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] state_q;
    logic [W-1:0] ev;

    assign ev = (val_i & ~prev_q & rise_en_i)
              | (~val_i & prev_q & fall_en_i)
              | (val_i & high_en_i)
              | (~val_i & low_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            state_q <= '0;
        end else begin
            prev_q  <= val_i;
            state_q <= (state_q & ~clr_i) | ev | frc_i;
        end
    end

    assign val_q_o = prev_q;
    assign state_o = state_q;
endmodule

// File: rtl/pev_top.sv
module pev_top
    import pev_pkg::*;
#(
    parameter int NPINS         = 32,
    parameter int STABLE_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_i,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NPINS-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [NPINS-1:0] rd_data,
    output logic [NPINS-1:0] irq_o
);
    typedef struct packed {
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] high;
        logic [NPINS-1:0] low;
    } trig_cfg_t;

    trig_cfg_t        trig_q;
    logic [NPINS-1:0] ien_q;
    logic [NPINS-1:0] filt_en_q;
    logic [NPINS-1:0] synced;
    logic [NPINS-1:0] val;
    logic [NPINS-1:0] val_q;
    logic [NPINS-1:0] state_q;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] frc;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q    <= '0;
            ien_q     <= '0;
            filt_en_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_IEN:  ien_q       <= wr_data;
                SEL_RISE: trig_q.rise <= wr_data;
                SEL_FALL: trig_q.fall <= wr_data;
                SEL_HIGH: trig_q.high <= wr_data;
                SEL_LOW:  trig_q.low  <= wr_data;
                SEL_FILT: filt_en_q   <= wr_data;
                default: ;
            endcase
        end
    end

    assign clr = hits(wr_en, wr_sel, SEL_STATE) ? wr_data : '0;
    assign frc = hits(wr_en, wr_sel, SEL_FORCE) ? wr_data : '0;

    pev_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pins_i),
        .sync_o (synced)
    );

    pev_filter #(.W(NPINS), .STABLE(STABLE_CYCLES)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .sync_i (synced),
        .en_i   (filt_en_q),
        .val_o  (val)
    );

    pev_detect #(.W(NPINS)) u_det (
        .clk       (clk),
        .rst       (rst),
        .val_i     (val),
        .rise_en_i (trig_q.rise),
        .fall_en_i (trig_q.fall),
        .high_en_i (trig_q.high),
        .low_en_i  (trig_q.low),
        .clr_i     (clr),
        .frc_i     (frc),
        .val_q_o   (val_q),
        .state_o   (state_q)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_PINS:  rd_data = val;
            SEL_STATE: rd_data = state_q;
            SEL_IEN:   rd_data = ien_q;
            SEL_RISE:  rd_data = trig_q.rise;
            SEL_FALL:  rd_data = trig_q.fall;
            SEL_HIGH:  rd_data = trig_q.high;
            SEL_LOW:   rd_data = trig_q.low;
            SEL_FILT:  rd_data = filt_en_q;
            default:   rd_data = '0;
        endcase
    end

    assign irq_o = state_q & ien_q;
endmodule

// File: rtl/pev_top_chk.sv
module pev_top_chk
    import pev_pkg::*;
#(
    parameter int W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [W-1:0]     wr_data,
    input logic [W-1:0]     val,
    input logic [W-1:0]     val_q,
    input logic [W-1:0]     rise,
    input logic [W-1:0]     high,
    input logic [W-1:0]     state_q,
    input logic [W-1:0]     irq_o
);
    p_irq_known_r12: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(irq_o));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_STATE)
        |=> ((state_q & $past(state_q)) == $past(state_q)));

    p_inject_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_FORCE)
        |=> ((state_q & $past(wr_data)) == $past(wr_data)));

    p_rise_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (|(val & ~val_q & rise))
        |=> ((state_q & $past(val & ~val_q & rise)) == $past(val & ~val_q & rise)));

    p_level_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (|(val & high))
        |=> ((state_q & $past(val & high)) == $past(val & high)));
endmodule

bind pev_top pev_top_chk #(.W(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .val     (val),
    .val_q   (val_q),
    .rise    (trig_q.rise),
    .high    (trig_q.high),
    .state_q (state_q),
    .irq_o   (irq_o)
);

// File: tb/pev_top_tb.sv
`timescale 1ns/1ps
module pev_top_tb;
    localparam int NP = 8;
    localparam int ST = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_sel = '0;
    logic [NP-1:0] wr_data = '0;
    logic [3:0]    rd_sel = '0;
    logic [NP-1:0] rd_data;
    logic [NP-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pev_top #(.NPINS(NP), .STABLE_CYCLES(ST), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq)
    );

    // behavioural reference state
    logic [NP-1:0] m_s1, m_s2, m_last, m_held, m_vprev, m_state;
    logic [NP-1:0] m_ien, m_rise, m_fall, m_high, m_low, m_filt;
    int m_run [NP];

    function automatic logic [NP-1:0] m_val();
        return (m_filt & m_held) | (~m_filt & m_s2);
    endfunction

    function automatic logic [NP-1:0] m_read(input int sel);
        case (sel)
            0: return m_val();
            1: return m_state;
            2: return m_ien;
            4: return m_rise;
            5: return m_fall;
            6: return m_high;
            7: return m_low;
            8: return m_filt;
            default: return '0;
        endcase
    endfunction

    task automatic model_tick();
        logic [NP-1:0] v, ev, clr, frc;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_last = '0; m_held = '0; m_vprev = '0; m_state = '0;
            m_ien = '0; m_rise = '0; m_fall = '0; m_high = '0; m_low = '0; m_filt = '0;
            for (int i = 0; i < NP; i++) m_run[i] = 0;
            return;
        end
        v   = m_val();
        ev  = (v & ~m_vprev & m_rise) | (~v & m_vprev & m_fall) | (v & m_high) | (~v & m_low);
        clr = (wr_en && wr_sel == 4'd1) ? wr_data : '0;
        frc = (wr_en && wr_sel == 4'd3) ? wr_data : '0;
        m_state = (m_state & ~clr) | ev | frc;
        for (int i = 0; i < NP; i++) begin
            if (m_s2[i] == m_last[i]) m_run[i] = (m_run[i] + 1 > ST) ? ST : m_run[i] + 1;
            else                      m_run[i] = 1;
            if (m_run[i] >= ST) m_held[i] = m_s2[i];
            m_last[i] = m_s2[i];
        end
        m_vprev = v;
        m_s2 = m_s1;
        m_s1 = pins;
        if (wr_en) begin
            case (wr_sel)
                4'd2: m_ien  = wr_data;
                4'd4: m_rise = wr_data;
                4'd5: m_fall = wr_data;
                4'd6: m_high = wr_data;
                4'd7: m_low  = wr_data;
                4'd8: m_filt = wr_data;
                default: ;
            endcase
        end
    endtask

    task automatic cmp(input string tag);
        logic [NP-1:0] exp_rd, exp_irq;
        exp_rd  = m_read(int'(rd_sel));
        exp_irq = m_state & m_ien;
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s read sel %0d: actual %h expected %h", tag, rd_sel, rd_data, exp_rd);
        end
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq: actual %h expected %h", tag, irq, exp_irq);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic wr(input int sel, input logic [NP-1:0] d, input string tag);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
        step(tag);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic hold(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        hold(3, "R1");
        rst = 1'b0;
        for (int s = 0; s < 16; s++) begin
            rd_sel = 4'(s); #1; cmp("R1"); // R13: codes 9..15 read zero
        end

        // R2: unfiltered pins through two-flop resync
        rd_sel = 4'd0;
        pins = 8'hA5; hold(3, "R2");
        pins = 8'h3C; step("R2"); step("R2"); step("R2");
        for (int k = 0; k < 20; k++) begin
            pins = 8'($urandom); step("R2");
        end

        // R3: filter on every pin, pulses around the threshold
        pins = '0; hold(4, "R3");
        wr(8, 8'hFF, "R3");
        for (int len = 3; len <= 6; len++) begin
            pins = 8'h01; hold(len, "R3");
            pins = 8'h00; hold(ST + 4, "R3");
        end
        pins = 8'hF0; hold(ST + 4, "R3");
        pins = 8'h00; hold(2, "R3"); pins = 8'hF0; hold(ST + 3, "R3");

        // R4: mixed filter mask, per-pin independence
        wr(8, 8'h0F, "R4");
        for (int k = 0; k < 40; k++) begin
            pins = 8'($urandom); step("R4");
        end
        for (int k = 0; k < 20; k++) begin
            pins = {pins[7:4], ~pins[3:0]}; step("R4");
        end

        // R5 / R6: edge events, masked interrupts
        wr(8, 8'h00, "R5");
        pins = 8'h00; hold(4, "R5");
        wr(1, 8'hFF, "R9");
        wr(2, 8'hFF, "R12");
        wr(4, 8'hAA, "R5");
        rd_sel = 4'd1;
        pins = 8'hFF; hold(4, "R5");
        wr(1, 8'hFF, "R9");
        wr(5, 8'h55, "R6");
        pins = 8'h00; hold(4, "R6");
        wr(1, 8'h0F, "R9"); hold(2, "R9");
        wr(1, 8'h00, "R9"); hold(2, "R9");
        wr(1, 8'hF0, "R9"); hold(2, "R9");

        // R7 / R8: level events, clear against held level
        wr(4, 8'h00, "R7"); wr(5, 8'h00, "R7");
        pins = 8'h33; hold(3, "R7");
        wr(6, 8'h0F, "R7"); hold(3, "R7");
        wr(7, 8'hF0, "R8"); hold(3, "R8");
        wr(1, 8'hFF, "R10"); hold(2, "R10");
        wr(6, 8'h00, "R10"); wr(7, 8'h00, "R10");
        wr(1, 8'hFF, "R9"); hold(2, "R9");

        // R11: injection register
        wr(3, 8'h81, "R11"); hold(2, "R11");
        rd_sel = 4'd3; #1; cmp("R11");
        rd_sel = 4'd1;
        wr(2, 8'h0F, "R12"); hold(2, "R12");
        wr(3, 8'h7E, "R11"); hold(2, "R11");

        // R13: read-back of written registers
        wr(4, 8'h12, "R13"); wr(5, 8'h34, "R13"); wr(6, 8'h56, "R13");
        wr(7, 8'h78, "R13"); wr(8, 8'h9A, "R13");
        for (int s = 0; s < 16; s++) begin
            rd_sel = 4'(s); #1; cmp("R13");
        end

        // mixed soak across all requirements (R3 R5 R9 R12)
        for (int k = 0; k < 400; k++) begin
            rd_sel = 4'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) pins = 8'($urandom);
            if ($urandom_range(0, 5) == 0) wr($urandom_range(1, 8), 8'($urandom), "R12");
            else step("R12");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule